// File: doc/BRIEF.md
# Programmable sample-timing waveform sequencer

This block paces a parallel-bus sampler. A host presents a start command made of a coarse delay byte, a fine delay byte, a clock-output enable and a sample-width flag. On an accepted command the block writes a short program into a table of waveform slots. Each slot holds a delay-or-branch word, an opcode, a six-bit control pattern and a logic-function word. The program has some delay slots followed by one decision slot. The engine then runs the program: each delay slot holds the control outputs for its count, and the decision slot writes one bus sample to a downstream FIFO.

After the sample the engine evaluates its branch condition, which is the FIFO full flag. It loops back to slot 0 while the FIFO has room and goes idle once the FIFO reports full. The sample period is built from whole 256-cycle slots plus one remainder slot. With clock output enabled, control lines 1 and 2 are driven high for the first phase and low for the rest, which gives a sample clock. The host must wait for idle before it issues a new command.

Top module: `sampleSequencer`

## Requirements
- R1: A start command is rejected, and busy stays 0, when both delay bytes are zero or when the coarse byte is 6 or more. Otherwise a start seen while idle is accepted.
- R2: A delay slot whose count field is 0 lasts 256 clocks; a nonzero field lasts exactly that many clocks. The decision slot lasts one clock.
- R3: With clock output disabled, the program is one 256-clock slot for each count of the coarse byte, then one slot of fine-byte length if the fine byte is nonzero. The control outputs are 0 throughout.
- R4: With clock output enabled and a nonzero coarse byte, each 256-clock slot drives control pattern 0x06 (lines 1 and 2 high). A final slot with the fine byte as its count field then drives 0x00.
- R5: With clock output enabled and a coarse byte of 0, the first slot has count field floor(fine/2) and pattern 0x06. The second slot has count field fine minus that and pattern 0x00.
- R6: In the decision slot the write strobe is high for exactly one clock and the control outputs are 0.
- R7: In wide mode the FIFO write data is the full 16-bit bus. Otherwise it is bus bits 7:0 zero-extended.
- R8: After the decision slot the engine returns to slot 0 if the FIFO full input was 0 in that clock. If it was 1, the engine goes idle in the next clock.
- R9: Busy rises in the clock after an accepted start and falls in the clock after the final decision slot. Idle is the inverse of busy. While idle, the control outputs and the write strobe are 0.
- R10: A start presented while busy is ignored, and the running program continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command present this clock |
| startHigh | input | 8 | Coarse delay: number of 256-clock slots |
| startLow | input | 8 | Fine delay: remainder count |
| clkOutEn | input | 1 | Produce a sample clock on control lines 1 and 2 |
| wideMode | input | 1 | 1: 16-bit samples, 0: 8-bit samples |
| busData | input | 16 | Sampled parallel bus |
| fifoFull | input | 1 | Downstream FIFO full flag |
| ctlOut | output | 6 | Control-output pattern |
| fifoWrEn | output | 1 | Sample write strobe |
| fifoWrData | output | 16 | Sample written to the FIFO |
| idle | output | 1 | Engine idle |
| busy | output | 1 | Engine running a program |

## Verification
The bench builds the block with its default 16-bit bus, a limit of 6 on the coarse byte, and seven program slots. The bench sweeps every accepted coarse value from 0 to 5 against fine values 0, 1, 2, 7 and 255, in both clock-output settings. This covers the 256-clock count for a zero field, the fine value of 1 whose first clock phase becomes a 256-clock slot, and the longest six-slot program. It also exercises looping over two passes, both sample widths, the rejected commands at the coarse limit and above, and a start issued mid-run.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int FIELD_W = 8;
  localparam int CTL_W = 6;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDLE_IDX = '1;
  localparam logic [2:0] TERM_FULL = 3'd6;
  localparam int OP_DP = 0;
  localparam int OP_DATA = 1;
  localparam logic [CTL_W-1:0] CLK_PAT = 6'h06;

  typedef struct packed {
    logic [FIELD_W-1:0] word;
    logic [FIELD_W-1:0] opcode;
    logic [CTL_W-1:0]   outPat;
    logic [FIELD_W-1:0] logicFn;
  } waveEntry_t;

  typedef struct packed {
    logic load;
    logic capture;
  } seqStrobe_t;

  function automatic waveEntry_t makeEntry(input int unsigned idx,
                                           input logic [7:0] hi,
                                           input logic [7:0] lo,
                                           input logic clkEn);
    waveEntry_t e;
    int unsigned nDelay;
    logic [7:0] half;
    e = '0;
    half = lo >> 1;
    if (clkEn && hi == 8'd0) nDelay = 2;
    else if (clkEn) nDelay = 32'(hi) + 1;
    else nDelay = 32'(hi) + ((lo != 8'd0) ? 32'd1 : 32'd0);
    if (idx < nDelay) begin
      if (clkEn && hi == 8'd0) begin
        e.word = (idx == 0) ? half : lo - half;
        e.outPat = (idx == 0) ? CLK_PAT : '0;
      end else if (idx < 32'(hi)) begin
        e.word = '0;
        e.outPat = clkEn ? CLK_PAT : '0;
      end else begin
        e.word = lo;
      end
    end else if (idx == nDelay) begin
      e.word = {2'b00, IDLE_IDX, 3'd0};
      e.opcode = 8'b0000_0011;
      e.logicFn = {2'b00, TERM_FULL, TERM_FULL};
    end
    return e;
  endfunction
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int BUS_W = 16,
  parameter int MAX_HIGH = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [7:0]         cmdHigh,
  input  logic [7:0]         cmdLow,
  input  logic               cmdClkEn,
  input  logic               cmdWide,
  input  logic [IDX_W-1:0]   curIdx,
  input  logic               running,
  input  logic [BUS_W-1:0]   busData,
  output logic               cmdOk,
  output waveEntry_t         curEntry,
  output logic [CTL_W-1:0]   ctlOut,
  output logic [BUS_W-1:0]   fifoWrData
);
  localparam int NUM_SLOTS = (1 << IDX_W) - 1;

  waveEntry_t slotTab [NUM_SLOTS];
  logic wideQ;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) slotTab[g] <= '0;
      else if (strobe.load) slotTab[g] <= makeEntry(g, cmdHigh, cmdLow, cmdClkEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wideQ <= 1'b0;
    else if (strobe.load) wideQ <= cmdWide;
  end

  assign cmdOk = (cmdHigh < 8'(MAX_HIGH)) && ((cmdHigh | cmdLow) != 8'd0);

  always_comb begin
    curEntry = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (curIdx == IDX_W'(i)) curEntry = slotTab[i];
  end

  assign ctlOut = running ? curEntry.outPat : '0;

  always_comb begin
    if (!strobe.capture) fifoWrData = '0;
    else if (wideQ) fifoWrData = busData;
    else fifoWrData = {{(BUS_W-8){1'b0}}, busData[7:0]};
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             cmdOk,
  input  waveEntry_t       curEntry,
  input  logic             fifoFull,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic             running
);
  localparam int CNT_W = FIELD_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic opKnown, isDecision, termA, termB, cond;
  logic [IDX_W-1:0] target;

  assign opKnown = (curEntry.opcode[FIELD_W-1:2] == '0);
  assign isDecision = opKnown && curEntry.opcode[OP_DP];
  assign limit = (curEntry.word == '0) ? CNT_W'(1 << FIELD_W) : {1'b0, curEntry.word};
  assign termA = (curEntry.logicFn[5:3] == TERM_FULL) && fifoFull;
  assign termB = (curEntry.logicFn[2:0] == TERM_FULL) && fifoFull;
  assign cond = (curEntry.logicFn[7:6] == 2'b00) ? (termA && termB) : (termA || termB);
  assign target = cond ? curEntry.word[5:3] : curEntry.word[2:0];

  assign strobe.load = startValid && !running && cmdOk;
  assign strobe.capture = running && isDecision && curEntry.opcode[OP_DATA];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      curIdx <= '0;
      cnt <= CNT_W'(1);
    end else if (strobe.load) begin
      running <= 1'b1;
      curIdx <= '0;
      cnt <= CNT_W'(1);
    end else if (running) begin
      if (isDecision) begin
        cnt <= CNT_W'(1);
        if (target == IDLE_IDX) begin
          running <= 1'b0;
          curIdx <= '0;
        end else begin
          curIdx <= target;
        end
      end else if (cnt == limit) begin
        curIdx <= curIdx + 1'b1;
        cnt <= CNT_W'(1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sampleSequencer.sv
module sampleSequencer
  import seqPkg::*;
#(
  parameter int BUS_W = 16,
  parameter int MAX_HIGH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [7:0]       startHigh,
  input  logic [7:0]       startLow,
  input  logic             clkOutEn,
  input  logic             wideMode,
  input  logic [BUS_W-1:0] busData,
  input  logic             fifoFull,
  output logic [CTL_W-1:0] ctlOut,
  output logic             fifoWrEn,
  output logic [BUS_W-1:0] fifoWrData,
  output logic             idle,
  output logic             busy
);
  seqStrobe_t strobe;
  waveEntry_t curEntry;
  logic [IDX_W-1:0] curIdx;
  logic running, cmdOk;

  seqControl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .cmdOk(cmdOk),
    .curEntry(curEntry), .fifoFull(fifoFull), .strobe(strobe),
    .curIdx(curIdx), .running(running)
  );

  seqDatapath #(.BUS_W(BUS_W), .MAX_HIGH(MAX_HIGH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdHigh(startHigh),
    .cmdLow(startLow), .cmdClkEn(clkOutEn), .cmdWide(wideMode),
    .curIdx(curIdx), .running(running), .busData(busData),
    .cmdOk(cmdOk), .curEntry(curEntry), .ctlOut(ctlOut),
    .fifoWrData(fifoWrData)
  );

  assign fifoWrEn = strobe.capture;
  assign busy = running;
  assign idle = !running;
endmodule

// File: rtl/seqChecker.sv
module seqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic [7:0] startHigh,
  input logic [7:0] startLow,
  input logic       fifoFull,
  input logic [5:0] ctlOut,
  input logic       fifoWrEn,
  input logic       idle,
  input logic       busy
);
  logic badCmd;
  assign badCmd = (startHigh >= 8'd6) || (startHigh == 8'd0 && startLow == 8'd0);

  AST_REJECT_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && badCmd) |=> !busy); // R1
  AST_ACCEPT_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && !badCmd) |=> busy); // R9
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> !fifoWrEn); // R6
  AST_STROBE_CTL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (ctlOut == 6'h00)); // R6
  AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && fifoFull) |=> (!busy && idle)); // R8
  AST_ROOM_LOOPS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && !fifoFull) |=> busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!fifoWrEn && ctlOut == 6'h00)); // R9
  AST_PATTERN_SET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ctlOut == 6'h00 || ctlOut == 6'h06)); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !fifoWrEn) |=> busy); // R10
endmodule

bind sampleSequencer seqChecker u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startHigh(startHigh),
  .startLow(startLow), .fifoFull(fifoFull), .ctlOut(ctlOut),
  .fifoWrEn(fifoWrEn), .idle(idle), .busy(busy)
);

// File: tb/sampleSequencer_tb.sv
`timescale 1ns/1ps
module sampleSequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [7:0] startHigh = '0, startLow = '0;
  logic clkOutEn = 1'b0, wideMode = 1'b0;
  logic [15:0] busData = '0;
  logic fifoFull = 1'b0;
  logic [5:0] ctlOut;
  logic fifoWrEn, idle, busy;
  logic [15:0] fifoWrData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sampleSequencer u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startHigh(startHigh),
    .startLow(startLow), .clkOutEn(clkOutEn), .wideMode(wideMode),
    .busData(busData), .fifoFull(fifoFull), .ctlOut(ctlOut),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .idle(idle), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int fieldLen(input int f);
    return (f == 0) ? 256 : f;
  endfunction

  task automatic runCmd(input int h, input int l, input bit ck, input bit wd,
                        input int passes, input bit poke);
    int lens[8];
    int pats[8];
    int n = 0;
    string tag;
    tag = ck ? ((h == 0) ? "R5" : "R4") : "R3";
    if (ck && h == 0) begin
      lens[0] = fieldLen(l / 2); pats[0] = 6;
      lens[1] = fieldLen(l - l / 2); pats[1] = 0;
      n = 2;
    end else begin
      for (int i = 0; i < h; i++) begin lens[n] = 256; pats[n] = ck ? 6 : 0; n++; end
      if (ck || l != 0) begin lens[n] = fieldLen(l); pats[n] = 0; n++; end
    end
    @(negedge clk);
    startHigh = 8'(h); startLow = 8'(l); clkOutEn = ck; wideMode = wd; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    #1;
    chk(busy == 1'b1 && idle == 1'b0, "R9 busy after start", int'(busy), 1);
    for (int p = 0; p < passes; p++) begin
      for (int s = 0; s < n; s++) begin
        int misses = 0;
        for (int c = 0; c < lens[s]; c++) begin
          if (poke && p == 0 && s == 0 && c == 1) begin
            startValid = 1'b1; startHigh = 8'd1; startLow = 8'd3; clkOutEn = !ck;
          end else if (poke && p == 0 && s == 0 && c == 2) begin
            startValid = 1'b0;
          end
          if (int'(ctlOut) != pats[s] || fifoWrEn) misses++;
          @(negedge clk);
        end
        chk(misses == 0, poke ? "R10 program unchanged" : tag, misses, 0);
      end
      busData = 16'(h * 4099 + l * 77 + p * 13 + 16'h5A00);
      fifoFull = (p == passes - 1);
      #1;
      chk(fifoWrEn == 1'b1, "R2 decision timing", int'(fifoWrEn), 1);
      chk(ctlOut == 6'h00, "R6 decision ctl", int'(ctlOut), 0);
      chk(fifoWrData == (wd ? busData : {8'h00, busData[7:0]}), "R7 sample width",
          int'(fifoWrData), int'(wd ? busData : {8'h00, busData[7:0]}));
      @(negedge clk);
      fifoFull = 1'b0;
      #1;
      if (p == passes - 1)
        chk(busy == 1'b0 && idle == 1'b1 && ctlOut == 0 && !fifoWrEn,
            "R8 idle after full", int'(busy), 0);
      else
        chk(busy == 1'b1 && !fifoWrEn && int'(ctlOut) == pats[0],
            "R8 loop to slot 0", int'(ctlOut), pats[0]);
    end
  endtask

  task automatic rejectCmd(input int h, input int l);
    int misses = 0;
    @(negedge clk);
    startHigh = 8'(h); startLow = 8'(l); clkOutEn = 1'b1; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    #1;
    chk(busy == 1'b0 && idle == 1'b1, "R1 rejected", int'(busy), 0);
    for (int c = 0; c < 5; c++) begin
      if (ctlOut != 0 || fifoWrEn || busy) misses++;
      @(negedge clk);
    end
    chk(misses == 0, "R1 stays idle", misses, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lset[5];
    lset[0] = 0; lset[1] = 1; lset[2] = 2; lset[3] = 7; lset[4] = 255;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(busy == 0 && idle == 1 && ctlOut == 0 && fifoWrEn == 0, "R9 reset state", int'(busy), 0);
    rejectCmd(0, 0);
    rejectCmd(6, 1);
    rejectCmd(9, 3);
    for (int h = 0; h < 6; h++)
      for (int li = 0; li < 5; li++)
        for (int ck = 0; ck < 2; ck++) begin
          if (h == 0 && lset[li] == 0) continue;
          runCmd(h, lset[li], ck[0], lset[li][0], (h <= 1) ? 2 : 1, h == 1 && lset[li] == 7);
        end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule